// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block turns a pair of parallel stereo samples into a serial bit stream, most significant bit first, in two's complement. It does not make its own bit or frame timing. An outside bit clock, word clock and left/right clock drive it. All three are sampled as levels in the `clk_i` domain, and `clk_i` must run several times faster than the bit clock. Three mode pins set the launch edge, the start event and an optional one-bit lead before the MSB.

At each start event the block latches the sample for the channel named by the left/right level: high selects the left channel, low selects the right channel. It then sends that sample one bit per launch edge. The receiver may stop taking bits after any count from 4 to the full width. A new start event cancels the current word and begins the next one. After the last bit of a word, the line stays low until the next start event. A mute input clears the line at once.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst_ni` is low, `sdata_o` is 0.
- R2: `sdata_o` changes only on launch edges of `bclk_i`, unless `mute_i` changes. With `bclk_inv_i`=0 the launch edge is the falling edge. With `bclk_inv_i`=1 it is the rising edge. The output is updated one `clk_i` cycle after the edge is sampled.
- R3: A word is W bits (24 by default), sent from bit W-1 down to bit 0, one bit per launch edge.
- R4: With `trig_lr_i`=0, a start event is a launch edge at which `wclk_i` is 1 and `wclk_i` was 0 at the previous launch edge. The channel is left if `lrclk_i` is 1 at that edge, and right otherwise.
- R5: With `trig_lr_i`=1, any change of `lrclk_i` between launch edges is a start event. A change to 1 starts the left field. A change to 0 starts the right field.
- R6: With `msb_dly_i`=0, the MSB goes out on the start launch edge itself. With `msb_dly_i`=1, a 0 goes out on that edge and the MSB goes out on the following launch edge.
- R7: While `mute_i` is 1, `sdata_o` is 0.
- R8: A start event before the word is complete abandons the rest of that word and sends the MSB of the new word. This lets the receiver take as few as 4 bits per channel.
- R9: After bit 0 has been sent, `sdata_o` stays 0 until the next start event.
- R10: The sample is captured at its start event. A change to `left_i` or `right_i` during a field does not alter the bits of that field.
- R11: A start event on the launch edge right after bit 0 sends the next field with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | External bit clock level |
| wclk_i | input | 1 | External word clock level |
| lrclk_i | input | 1 | External left/right clock level |
| bclk_inv_i | input | 1 | 0: launch on falling edge; 1: launch on rising edge |
| trig_lr_i | input | 1 | 0: word-clock start; 1: left/right start |
| msb_dly_i | input | 1 | 1: one-bit lead before the MSB |
| mute_i | input | 1 | Forces the output to zero |
| left_i | input | W | Left channel sample |
| right_i | input | W | Right channel sample |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions check three things on every cycle, using only the port pins: the output is quiet during reset, the output does not move away from launch edges unless mute changes, and mute forces the line to zero. They also check that a delayed start puts a zero on the line first. The following behaviours can only be shown by the bench's scenarios, with a queue-based model compared every clock: correct bit order and sample values, channel choice in both trigger modes, truncated and back-to-back fields, the idle zeros after a word ends, and ignoring a sample that changes mid-field.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  typedef struct packed {
    logic  launch;
    logic  start;
    chan_e chan;
  } frame_evt_t;
endpackage

// File: rtl/atx_edge_det.sv
module atx_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic bclk_inv_i,
  output logic launch_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  // launch edge: falling when not inverted, rising when inverted
  always_comb begin
    if (bclk_inv_i) launch_o = bclk_i & ~bclk_q;
    else            launch_o = ~bclk_i & bclk_q;
  end
endmodule

// File: rtl/atx_start_det.sv
module atx_start_det
  import audio_ser_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       wclk_i,
  input  logic       lrclk_i,
  input  logic       trig_lr_i,
  output frame_evt_t evt_o
);
  logic frm_cur, frm_q, start;

  assign frm_cur = trig_lr_i ? lrclk_i : wclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frm_q <= 1'b0;
    else if (launch_i) frm_q <= frm_cur;
  end

  always_comb begin
    if (trig_lr_i) start = frm_cur ^ frm_q;
    else           start = frm_cur & ~frm_q;
  end

  assign evt_o.launch = launch_i;
  assign evt_o.start  = launch_i & start;
  assign evt_o.chan   = lrclk_i ? CH_LEFT : CH_RIGHT;
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         launch_i,
  input  logic         start_i,
  input  logic         dly_i,
  input  logic [W-1:0] sample_i,
  output logic         bit_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg    <= '0;
      left_cnt <= '0;
      bit_o    <= 1'b0;
    end else if (launch_i) begin
      if (start_i) begin
        if (dly_i) begin
          shreg    <= sample_i;
          left_cnt <= CW'(W);
          bit_o    <= 1'b0;
        end else begin
          shreg    <= {sample_i[W-2:0], 1'b0};
          left_cnt <= CW'(W - 1);
          bit_o    <= sample_i[W-1];
        end
      end else if (left_cnt != '0) begin
        shreg    <= {shreg[W-2:0], 1'b0};
        left_cnt <= left_cnt - 1'b1;
        bit_o    <= shreg[W-1];
      end else begin
        bit_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_tx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic         wclk_i,
  input  logic         lrclk_i,
  input  logic         bclk_inv_i,
  input  logic         trig_lr_i,
  input  logic         msb_dly_i,
  input  logic         mute_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  output logic         sdata_o
);
  logic         launch;
  frame_evt_t   evt;
  logic [W-1:0] sample_sel;
  logic         tx_bit;

  atx_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .bclk_inv_i (bclk_inv_i),
    .launch_o   (launch)
  );

  atx_start_det u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .wclk_i    (wclk_i),
    .lrclk_i   (lrclk_i),
    .trig_lr_i (trig_lr_i),
    .evt_o     (evt)
  );

  assign sample_sel = (evt.chan == CH_LEFT) ? left_i : right_i;

  atx_shifter #(.W(W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (evt.launch),
    .start_i  (evt.start),
    .dly_i    (msb_dly_i),
    .sample_i (sample_sel),
    .bit_o    (tx_bit)
  );

  assign sdata_o = tx_bit & ~mute_i;
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bclk_i,
  input logic         wclk_i,
  input logic         lrclk_i,
  input logic         bclk_inv_i,
  input logic         trig_lr_i,
  input logic         msb_dly_i,
  input logic         mute_i,
  input logic [W-1:0] left_i,
  input logic [W-1:0] right_i,
  input logic         sdata_o
);
  logic b_q, f_q, launch_c, start_c, launch_d, f_now;

  assign launch_c = bclk_inv_i ? (bclk_i & ~b_q) : (~bclk_i & b_q);
  assign f_now    = trig_lr_i ? lrclk_i : wclk_i;
  assign start_c  = trig_lr_i ? (f_now ^ f_q) : (f_now & ~f_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q      <= 1'b0;
      f_q      <= 1'b0;
      launch_d <= 1'b0;
    end else begin
      b_q      <= bclk_i;
      launch_d <= launch_c;
      if (launch_c) f_q <= f_now;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (sdata_o == 1'b0));

  p_launch_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdata_o) && $stable(mute_i)) |-> launch_d);

  p_lead_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_c && start_c && msb_dly_i) |=> (sdata_o == 1'b0));

  p_mute_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> (sdata_o == 1'b0));

  logic unused_ok;
  assign unused_ok = ^{left_i, right_i};
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_i     (bclk_i),
  .wclk_i     (wclk_i),
  .lrclk_i    (lrclk_i),
  .bclk_inv_i (bclk_inv_i),
  .trig_lr_i  (trig_lr_i),
  .msb_dly_i  (msb_dly_i),
  .mute_i     (mute_i),
  .left_i     (left_i),
  .right_i    (right_i),
  .sdata_o    (sdata_o)
);

// File: tb/sim_audio_ser_tx.sv
`timescale 1ns/1ps
module sim_audio_ser_tx;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, lrclk = 1'b0;
  logic pol = 1'b0, trg = 1'b0, dly = 1'b0, mute = 1'b0;
  logic [W-1:0] left_s = '0, right_s = '0;
  logic sdata;

  int total = 0;
  int bad = 0;
  string req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  audio_ser_tx #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .wclk_i(wclk), .lrclk_i(lrclk),
    .bclk_inv_i(pol), .trig_lr_i(trg), .msb_dly_i(dly), .mute_i(mute),
    .left_i(left_s), .right_i(right_s), .sdata_o(sdata)
  );

  // behavioural reference: queue of bits pending on the line
  logic m_prev_b = 1'b0, m_prev_f = 1'b0, m_exp = 1'b0;
  logic m_q[$];

  always @(posedge clk) begin
    logic launch, cur_f, start;
    logic [W-1:0] smp;
    if (!rst_n) begin
      m_prev_b = 1'b0; m_prev_f = 1'b0; m_exp = 1'b0; m_q.delete();
    end else begin
      launch = pol ? (bclk && !m_prev_b) : (!bclk && m_prev_b);
      cur_f  = trg ? lrclk : wclk;
      start  = trg ? (cur_f != m_prev_f) : (cur_f && !m_prev_f);
      if (launch) begin
        m_prev_f = cur_f;
        if (start) begin
          m_q.delete();
          smp = lrclk ? left_s : right_s;
          if (dly) m_q.push_back(1'b0);
          for (int i = W - 1; i >= 0; i--) m_q.push_back(smp[i]);
        end
        m_exp = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
      end
      m_prev_b = bclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e;
      e = m_exp & ~mute;
      total++;
      if (sdata !== e) begin
        bad++;
        $display("FAIL %s t=%0t sdata=%b expected=%b", req, $time, sdata, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic slot(input logic lr, input logic wc);
    bclk = ~pol; tick(); tick();
    bclk = pol; lrclk = lr; wclk = wc; tick(); tick();
  endtask

  task automatic field(input logic lr, input int n);
    slot(lr, 1'b1);
    for (int i = 1; i < n; i++) slot(lr, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(lrclk, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    total++;
    if (sdata !== 1'b0) begin
      bad++; $display("FAIL R1 reset sdata=%b expected=0", sdata);
    end
    tick(); rst_n = 1'b1; tick();
    idle(2);

    // R3 R4 word-clock start, falling launch, MSB first, idle zeros (R9)
    req = "R4"; left_s = 24'hA5C3F1; right_s = 24'h5A0C1E;
    lrclk = 1'b1; idle(1);
    field(1'b1, 24); idle(3);
    req = "R3"; lrclk = 1'b0; idle(1);
    field(1'b0, 24);
    req = "R9"; idle(6);

    // R5 R11 left/right trigger, back-to-back fields
    req = "R5"; trg = 1'b1; left_s = 24'h800001; right_s = 24'h7FFFFE;
    field(1'b1, 24);
    req = "R11"; field(1'b0, 24); field(1'b1, 24); field(1'b0, 24);
    idle(2);

    // R6 one-bit lead
    req = "R6"; dly = 1'b1; left_s = 24'hFFFFFF; right_s = 24'h123456;
    field(1'b1, 25); field(1'b0, 25); field(1'b1, 26);
    dly = 1'b0; idle(2);

    // R2 inverted polarity, both trigger modes
    req = "R2"; pol = 1'b1; idle(2);
    left_s = 24'h3C96E1; right_s = 24'hC3691E;
    field(1'b0, 24); field(1'b1, 24);
    trg = 1'b0; field(1'b0, 24); idle(3);
    dly = 1'b1; field(1'b1, 25); dly = 1'b0; idle(2);
    pol = 1'b0; idle(2);

    // R8 truncation to 8 and 4 bits
    req = "R8"; trg = 1'b1; left_s = 24'hF0F0F0; right_s = 24'h0F0F0F;
    field(1'b1, 8); field(1'b0, 8); field(1'b1, 4); field(1'b0, 4);
    trg = 1'b0; field(1'b1, 5); field(1'b0, 4); idle(3);

    // R10 sample changes mid-field
    req = "R10"; trg = 1'b1; left_s = 24'hAAAAAA;
    slot(1'b0, 1'b0); slot(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) slot(1'b1, 1'b0);
    left_s = 24'h555555; right_s = 24'h000000;
    for (int i = 0; i < 18; i++) slot(1'b1, 1'b0);
    field(1'b0, 24); idle(2);

    // R7 mute during a field
    req = "R7"; left_s = 24'hFFFFFF; right_s = 24'hFFFFFF;
    slot(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b0);
    mute = 1'b1;
    for (int i = 0; i < 8; i++) slot(1'b1, 1'b0);
    tick(); mute = 1'b0;
    for (int i = 0; i < 10; i++) slot(1'b1, 1'b0);
    mute = 1'b1; field(1'b0, 24); mute = 1'b0; idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule